// File: doc/BRIEF.md
# Byte-Addressed Memory with Single-Error-Correcting Word Groups

This block is a small on-chip memory that the host sees as plain bytes, while storage is organised as aligned four-byte groups. Each group holds its 32 data bits together with 6 Hamming check bits, for 38 stored bits. The bytes at addresses 4N, 4N+1, 4N+2 and 4N+3 share one codeword. When a group is read, any single flipped bit among its 38 stored bits is repaired before the requested byte is returned. Check bits never appear at the host port, and the access protocol is the same as for an unprotected memory.

A read is accepted in one cycle, and its byte appears one cycle later. A byte write cannot just overwrite its 8 bits, because the check bits depend on the whole group. The write is therefore a two-cycle read-modify-write. In the first cycle the request is captured. In the second cycle the stored group is fetched and corrected, the new byte is merged in, and all 38 bits are re-encoded and written back. The request port is stalled during that second cycle.

A one-cycle flag reports every group fetch that needed a repair. A test-only injection port flips one chosen stored bit, so that the repair path can be exercised.

Top module: `sec_byte_mem`

## Requirements
- R1: Reset is synchronous and active-low. In the first cycle after `rst_n` is released, `rd_valid` = 0, `corr_event` = 0 and `req_ready` = 1. Every byte then reads as 0x00 without a correction flag.
- R2: A read is accepted when `req_valid` = 1, `req_write` = 0 and `req_ready` = 1 at a rising edge. After that edge, `rd_valid` is 1 for exactly one cycle and `rd_data` holds the byte at `req_addr`. Byte lane `req_addr[1:0]` = k is bits 8k+7..8k of group `req_addr[ADDR_W-1:2]`. `rd_valid` is 0 in every other cycle.
- R3: A write is accepted when `req_valid` = 1, `req_write` = 1 and `req_ready` = 1 at a rising edge. `req_ready` is then 0 for exactly the one following cycle. Afterwards the addressed byte reads back as `req_wdata`, and the other three bytes of its group are unchanged.
- R4: A single flipped bit at any of the 38 stored positions of a group (`inj_bit` 0 to 37) is corrected on read. All four bytes of that group return their written values.
- R5: `corr_event` is 1 in the cycle where `rd_valid` is 1 if the group that was read held a single-bit error. It is 0 for a clean group. A read does not repair the stored group.
- R6: A write into a group that holds a single-bit error stores a clean, corrected group. `corr_event` is 1 in the cycle right after the write's stall cycle. Later reads of any byte in that group return correct data with `corr_event` = 0.
- R7: When `inj_en` = 1 at a rising edge, stored bit `inj_bit` of group `inj_grp` is inverted. Values of `inj_bit` from 38 to 63 change nothing.
- R8: If an injection and a write-back hit the same group at the same edge, the inversion is applied to the newly written codeword. A later read returns the new data with `corr_event` = 1.
- R9: A read that is accepted at the same edge as an injection into its group returns the data as it was before the flip, with `corr_event` = 0. The next read of that group has `corr_event` = 1.
- R10: While `req_ready` = 0, a request on the port is ignored. A held write does not change memory, and a held read produces no `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = byte write, 0 = byte read |
| req_addr | input | ADDR_W | Byte address; bits [1:0] select the lane within the group |
| req_wdata | input | 8 | Byte to write |
| req_ready | output | 1 | Request port can accept (0 during the write-back cycle) |
| rd_valid | output | 1 | Read data valid, one cycle after the read is accepted |
| rd_data | output | 8 | Corrected read byte |
| corr_event | output | 1 | One-cycle pulse: the group just fetched needed a single-bit repair |
| inj_en | input | 1 | Test only: invert one stored bit at this edge |
| inj_grp | input | ADDR_W-2 | Test only: group whose bit is inverted |
| inj_bit | input | 6 | Test only: stored bit index, 0 to 37 effective |

## Verification
Two functions can act on the same group at the same edge. The first pair is the test injection and a write's write-back. The bench raises `inj_en` for the group during the stall cycle of a write, then reads back and expects the new byte together with a correction flag. The second pair is the injection and an accepted read. The bench asserts both in one cycle and expects the pre-flip data with no flag, then a flag on the following read of the same group.

// File: rtl/secmem_pkg.sv
`timescale 1ns/1ps
// Shared constants, types and constant functions for the protected
// byte memory. Assumes a Hamming layout over positions 1..CW_W with
// check bits at power-of-two positions; stored bit i holds position i+1.
package secmem_pkg;

    localparam int BYTE_W = 8;
    localparam int LANES  = 4;
    localparam int DATA_W = BYTE_W * LANES;
    localparam int CHK_W  = 6;
    localparam int CW_W   = DATA_W + CHK_W;

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [CW_W-1:0]   cw_t;
    typedef logic [CHK_W-1:0]  syn_t;

    // True when a codeword position (1-based) is reserved for a check bit.
    function automatic bit is_chk_pos(int p);
        return (p & (p - 1)) == 0;
    endfunction

    // Data bit index carried at a non-check position (1-based).
    function automatic int data_index(int p);
        int n;
        n = 0;
        for (int q = 1; q < p; q++) begin
            if (!is_chk_pos(q)) n++;
        end
        return n;
    endfunction

    // Check-bit index for a power-of-two position.
    function automatic int chk_index(int p);
        int k;
        k = 0;
        while ((1 << k) < p) k++;
        return k;
    endfunction

    // Stored bits whose position has bit k set.
    function automatic cw_t cover_mask(int k);
        cw_t m;
        m = '0;
        for (int p = 1; p <= CW_W; p++) begin
            m[p-1] = ((p >> k) & 1) != 0;
        end
        return m;
    endfunction

endpackage

// File: rtl/secmem_encoder.sv
`timescale 1ns/1ps
// Builds a 38-bit codeword from a 32-bit group.
// Assumes the package layout; purely combinational.
module secmem_encoder
    import secmem_pkg::*;
(
    input  word_t data_i,
    output cw_t   cw_o
);

    cw_t  scat;
    syn_t par;

    // Place data bits at their positions, check positions zeroed.
    for (genvar p = 1; p <= CW_W; p++) begin : g_scat
        if (is_chk_pos(p)) begin : g_zero
            assign scat[p-1] = 1'b0;
        end else begin : g_dat
            assign scat[p-1] = data_i[data_index(p)];
        end
    end

    // Each check bit is even parity over the positions it covers.
    for (genvar k = 0; k < CHK_W; k++) begin : g_par
        assign par[k] = ^(scat & cover_mask(k));
    end

    // Insert check bits at power-of-two positions.
    for (genvar p = 1; p <= CW_W; p++) begin : g_out
        if (is_chk_pos(p)) begin : g_chk
            assign cw_o[p-1] = par[chk_index(p)];
        end else begin : g_pass
            assign cw_o[p-1] = scat[p-1];
        end
    end

endmodule

// File: rtl/secmem_decoder.sv
`timescale 1ns/1ps
// Computes the syndrome of a stored codeword and repairs one bit.
// Assumes at most one flipped bit; a syndrome beyond CW_W is left unrepaired.
module secmem_decoder
    import secmem_pkg::*;
(
    input  cw_t   cw_i,
    output word_t data_o,
    output logic  err_o
);

    localparam syn_t LAST_POS = syn_t'(CW_W);

    syn_t syn;
    cw_t  flip;
    cw_t  fixed;

    // Syndrome bit k: parity over every position with bit k set.
    for (genvar k = 0; k < CHK_W; k++) begin : g_syn
        assign syn[k] = ^(cw_i & cover_mask(k));
    end

    // The syndrome names the faulty position; invert it.
    always_comb begin
        flip = '0;
        if (syn != '0 && syn <= LAST_POS) flip = cw_t'(1) << (syn - syn_t'(1));
        fixed = cw_i ^ flip;
    end

    // Gather data bits from their positions.
    for (genvar p = 1; p <= CW_W; p++) begin : g_dat
        if (!is_chk_pos(p)) begin : g_take
            assign data_o[data_index(p)] = fixed[p-1];
        end
    end

    assign err_o = (syn != '0);

endmodule

// File: rtl/secmem_store.sv
`timescale 1ns/1ps
// Flop array of codewords, one per group, with a combinational read port,
// one write port and a test bit-inversion port. The inversion is applied
// on top of a same-edge write to the same group.
module secmem_store
    import secmem_pkg::*;
#(
    parameter int GRP_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [GRP_W-1:0] rd_grp,
    output cw_t              rd_cw,
    input  logic             wr_en,
    input  logic [GRP_W-1:0] wr_grp,
    input  cw_t              wr_cw,
    input  logic             inj_en,
    input  logic [GRP_W-1:0] inj_grp,
    input  syn_t             inj_bit
);

    localparam int   N_GRP    = 1 << GRP_W;
    localparam syn_t LAST_BIT = syn_t'(CW_W);

    cw_t cells [N_GRP];
    cw_t inj_mask;

    // One-hot inversion mask; out-of-range indices give no inversion.
    always_comb begin
        inj_mask = '0;
        if (inj_bit < LAST_BIT) inj_mask = cw_t'(1) << inj_bit;
    end

    for (genvar g = 0; g < N_GRP; g++) begin : g_cell
        cw_t cell_q;
        cw_t cell_d;

        // Next value: write-back first, then optional test inversion.
        always_comb begin
            cell_d = (wr_en && wr_grp == GRP_W'(g)) ? wr_cw : cell_q;
            if (inj_en && inj_grp == GRP_W'(g)) cell_d = cell_d ^ inj_mask;
        end

        // Hold the codeword; reset to the all-zero codeword.
        always_ff @(posedge clk) begin
            if (!rst_n) cell_q <= '0;
            else        cell_q <= cell_d;
        end

        assign cells[g] = cell_q;
    end

    assign rd_cw = cells[rd_grp];

endmodule

// File: rtl/sec_byte_mem.sv
`timescale 1ns/1ps
// Byte-addressed memory with single-error correction per 4-byte group.
// Reads return one cycle after acceptance. Writes take an extra stall
// cycle to read, correct, merge and re-encode the whole group.
// Assumes requests are presented only when the host samples req_ready.
module sec_byte_mem
    import secmem_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [7:0]        req_wdata,
    output logic              req_ready,
    output logic              rd_valid,
    output logic [7:0]        rd_data,
    output logic              corr_event,
    input  logic              inj_en,
    input  logic [ADDR_W-3:0] inj_grp,
    input  logic [5:0]        inj_bit
);

    localparam int LANE_W = $clog2(LANES);
    localparam int GRP_W  = ADDR_W - LANE_W;

    logic              wr_pend;
    logic [ADDR_W-1:0] wr_addr;
    logic [7:0]        wr_byte;
    logic              acc_rd;
    logic              acc_wr;
    logic [GRP_W-1:0]  grp_sel;
    cw_t               old_cw;
    cw_t               new_cw;
    word_t             fix_word;
    word_t             merged;
    logic              fix_err;
    logic [7:0]        rd_byte;

    assign req_ready = !wr_pend;
    assign acc_rd    = req_valid && !wr_pend && !req_write;
    assign acc_wr    = req_valid && !wr_pend &&  req_write;

    // The pending write owns the array port during its stall cycle.
    assign grp_sel = wr_pend ? wr_addr[ADDR_W-1:LANE_W] : req_addr[ADDR_W-1:LANE_W];

    secmem_store #(.GRP_W(GRP_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_grp  (grp_sel),
        .rd_cw   (old_cw),
        .wr_en   (wr_pend),
        .wr_grp  (wr_addr[ADDR_W-1:LANE_W]),
        .wr_cw   (new_cw),
        .inj_en  (inj_en),
        .inj_grp (inj_grp),
        .inj_bit (inj_bit)
    );

    secmem_decoder u_dec (
        .cw_i   (old_cw),
        .data_o (fix_word),
        .err_o  (fix_err)
    );

    // Replace the addressed lane of the corrected group with the new byte.
    for (genvar l = 0; l < LANES; l++) begin : g_merge
        assign merged[l*BYTE_W +: BYTE_W] =
            (wr_addr[LANE_W-1:0] == LANE_W'(l)) ? wr_byte : fix_word[l*BYTE_W +: BYTE_W];
    end

    secmem_encoder u_enc (
        .data_i (merged),
        .cw_o   (new_cw)
    );

    assign rd_byte = fix_word[{req_addr[LANE_W-1:0], 3'b000} +: BYTE_W];

    // Request capture, read result register and correction pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_pend    <= 1'b0;
            wr_addr    <= '0;
            wr_byte    <= '0;
            rd_valid   <= 1'b0;
            rd_data    <= '0;
            corr_event <= 1'b0;
        end else begin
            wr_pend    <= acc_wr;
            rd_valid   <= acc_rd;
            corr_event <= (acc_rd || wr_pend) && fix_err;
            if (acc_wr) begin
                wr_addr <= req_addr;
                wr_byte <= req_wdata;
            end
            if (acc_rd) rd_data <= rd_byte;
        end
    end

endmodule

// File: rtl/sec_byte_mem_chk.sv
`timescale 1ns/1ps
// Port-level protocol checker for sec_byte_mem, attached by bind.
module sec_byte_mem_chk #(
    parameter int ADDR_W = 6
) (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_write,
    input logic req_ready,
    input logic rd_valid,
    input logic corr_event
);

    logic rd_take;
    logic wr_take;
    assign rd_take = req_valid && req_ready && !req_write;
    assign wr_take = req_valid && req_ready &&  req_write;

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!rd_valid && !corr_event && req_ready));

    assert_read_returns_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_take |=> rd_valid);

    assert_no_stray_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_take |=> !rd_valid);

    assert_write_stalls_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_take |=> !req_ready);

    assert_stall_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |=> req_ready);

    assert_flag_has_fetch_R5: assert property (@(posedge clk) disable iff (!rst_n)
        corr_event |-> ($past(rd_take) || $past(!req_ready)));

    assert_stall_blocks_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |=> !rd_valid);

endmodule

bind sec_byte_mem sec_byte_mem_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_ready  (req_ready),
    .rd_valid   (rd_valid),
    .corr_event (corr_event)
);

// File: tb/sec_byte_mem_test.sv
`timescale 1ns/1ps
module sec_byte_mem_test;

    localparam int ADDR_W = 6;
    localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_INJ = 2'd2;
    localparam int NV = 19;
    // {op, addr, arg (wdata or bit), expected byte, expected flag}
    localparam logic [24:0] VEC [NV] = '{
        {OP_WR,  6'h00, 8'hA1, 8'h00, 1'b0},
        {OP_WR,  6'h01, 8'hB2, 8'h00, 1'b0},
        {OP_WR,  6'h02, 8'hC3, 8'h00, 1'b0},
        {OP_WR,  6'h03, 8'hD4, 8'h00, 1'b0},
        {OP_RD,  6'h00, 8'h00, 8'hA1, 1'b0},
        {OP_RD,  6'h03, 8'h00, 8'hD4, 1'b0},
        {OP_INJ, 6'h00, 8'd5,  8'h00, 1'b0},
        {OP_RD,  6'h02, 8'h00, 8'hC3, 1'b1},
        {OP_RD,  6'h01, 8'h00, 8'hB2, 1'b1},
        {OP_WR,  6'h01, 8'h55, 8'h00, 1'b1},
        {OP_RD,  6'h00, 8'h00, 8'hA1, 1'b0},
        {OP_RD,  6'h01, 8'h00, 8'h55, 1'b0},
        {OP_WR,  6'h14, 8'h7E, 8'h00, 1'b0},
        {OP_INJ, 6'h14, 8'd0,  8'h00, 1'b0},
        {OP_RD,  6'h14, 8'h00, 8'h7E, 1'b1},
        {OP_RD,  6'h15, 8'h00, 8'h00, 1'b1},
        {OP_INJ, 6'h14, 8'd0,  8'h00, 1'b0},
        {OP_RD,  6'h14, 8'h00, 8'h7E, 1'b0},
        {OP_RD,  6'h3F, 8'h00, 8'h00, 1'b0}
    };

    logic              clk = 1'b0;
    logic              rst_n;
    logic              req_valid, req_write;
    logic [ADDR_W-1:0] req_addr;
    logic [7:0]        req_wdata;
    logic              req_ready, rd_valid, corr_event;
    logic [7:0]        rd_data;
    logic              inj_en;
    logic [ADDR_W-3:0] inj_grp;
    logic [5:0]        inj_bit;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 0;

    always #10 clk = ~clk;

    sec_byte_mem #(.ADDR_W(ADDR_W)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rd_valid(rd_valid), .rd_data(rd_data), .corr_event(corr_event),
        .inj_en(inj_en), .inj_grp(inj_grp), .inj_bit(inj_bit)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic do_read(input logic [5:0] a, output logic [7:0] d, output logic f);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R2 rd_valid after read", {31'b0, rd_valid}, 32'd1);
        d = rd_data; f = corr_event;
    endtask

    task automatic do_write(input logic [5:0] a, input logic [7:0] v, output logic f);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = v;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        f = corr_event;
    endtask

    task automatic do_inject(input logic [3:0] g, input logic [5:0] b);
        @(negedge clk);
        inj_en = 1'b1; inj_grp = g; inj_bit = b;
        @(posedge clk);
        @(negedge clk);
        inj_en = 1'b0;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0]  d;
        logic        f;
        logic [24:0] v;
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0;
        req_wdata = '0; inj_en = 1'b0; inj_grp = '0; inj_bit = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk("R1 req_ready", {31'b0, req_ready}, 32'd1);
        chk("R1 rd_valid", {31'b0, rd_valid}, 32'd0);
        chk("R1 corr_event", {31'b0, corr_event}, 32'd0);
        do_read(6'h20, d, f);
        chk("R1 data after reset", {24'b0, d}, 32'h0);
        chk("R1 flag after reset", {31'b0, f}, 32'd0);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            v = VEC[i];
            case (v[24:23])
                OP_WR: begin
                    do_write(v[22:17], v[16:9], f);
                    chk("R3 or R6 write flag", {31'b0, f}, {31'b0, v[0]});
                end
                OP_RD: begin
                    do_read(v[22:17], d, f);
                    chk("R2 read data", {24'b0, d}, {24'b0, v[8:1]});
                    chk("R5 read flag", {31'b0, f}, {31'b0, v[0]});
                end
                default: do_inject(v[22:19], v[14:9]);
            endcase
        end

        // R3 and R10: one stall cycle, held write ignored
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 6'h24; req_wdata = 8'h11;
        @(posedge clk);
        @(negedge clk);
        chk("R3 ready low in stall", {31'b0, req_ready}, 32'd0);
        req_addr = 6'h25; req_wdata = 8'h99;
        @(posedge clk);
        @(negedge clk);
        chk("R3 ready back", {31'b0, req_ready}, 32'd1);
        req_valid = 1'b0;
        do_read(6'h25, d, f);
        chk("R10 held write ignored", {24'b0, d}, 32'h00);
        do_read(6'h24, d, f);
        chk("R3 written byte", {24'b0, d}, 32'h11);

        // R10: held read during stall yields no rd_valid
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 6'h26; req_wdata = 8'h22;
        @(posedge clk);
        @(negedge clk);
        req_write = 1'b0; req_addr = 6'h24;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R10 no rd_valid for held read", {31'b0, rd_valid}, 32'd0);
        do_read(6'h26, d, f);
        chk("R3 second write", {24'b0, d}, 32'h22);
        do_read(6'h24, d, f);
        chk("R3 neighbour kept", {24'b0, d}, 32'h11);

        // R7: out-of-range bit index does nothing
        do_inject(4'd9, 6'd40);
        do_read(6'h24, d, f);
        chk("R7 data after bit 40", {24'b0, d}, 32'h11);
        chk("R7 no flag after bit 40", {31'b0, f}, 32'd0);

        // R8: injection at the write-back edge
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 6'h28; req_wdata = 8'h3C;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0; inj_en = 1'b1; inj_grp = 4'd10; inj_bit = 6'd20;
        @(posedge clk);
        @(negedge clk);
        inj_en = 1'b0;
        do_read(6'h28, d, f);
        chk("R8 new data", {24'b0, d}, 32'h3C);
        chk("R8 flag", {31'b0, f}, 32'd1);
        do_read(6'h29, d, f);
        chk("R8 neighbour", {24'b0, d}, 32'h00);
        chk("R8 neighbour flag", {31'b0, f}, 32'd1);

        // R9: injection at the read acceptance edge
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 6'h2C;
        inj_en = 1'b1; inj_grp = 4'd11; inj_bit = 6'd3;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0; inj_en = 1'b0;
        chk("R9 data", {24'b0, rd_data}, 32'h00);
        chk("R9 no flag", {31'b0, corr_event}, 32'd0);
        do_read(6'h2C, d, f);
        chk("R9 flag next read", {31'b0, f}, 32'd1);

        // R4: every stored position corrected
        do_write(6'h31, 8'hA5, f);
        for (int b = 0; b < 38; b++) begin
            do_inject(4'd12, 6'(b));
            do_read(6'h30 + 6'(b % 4), d, f);
            chk("R4 corrected data", {24'b0, d}, (b % 4 == 1) ? 32'hA5 : 32'h00);
            chk("R4 flag", {31'b0, f}, 32'd1);
            do_inject(4'd12, 6'(b));
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule